// File: doc/BRIEF.md
# Quadrature Encoder Clock Converter

This block turns the two phase-shifted square waves of a rotary or linear encoder into count pulses for an ordinary up/down counter. Both encoder lines arrive asynchronously. Each passes through a two-flop synchroniser and then a stability filter that only accepts a new level after it has held for a set number of system clocks. Dither at an edge therefore never reaches the outputs. The filtered pair of levels is decoded as a Gray-code sequence. An illegal jump, where both lines change together, is reported on a sticky flag and produces no pulse.

A resolution input picks between two modes. With the input high, every valid edge on either line counts. With it low, one count is made per full encoder cycle. Two output styles run side by side. The first is a pair of active-low pulse strings, one for up and one for down. The second is an active-low shared clock plus a direction level. The direction level only changes while the shared clock is high, so a counter that counts on the clock's rising edge always sees a settled direction.

The pulse width comes from an 8-bit input in system clocks. If a new count arrives while a pulse is still low, the running pulse is cut short. At least one high cycle follows, then the new pulse starts. Counts are queued in arrival order and none is lost. There is no stream interface: every pin is a plain level.

Top module: `qclk_conv`

## Requirements
- R1: After synchronisation, a new level on either encoder line is accepted only after it has differed from the accepted level for FILT_LEN consecutive clocks (default 4). A shorter glitch produces no pulse.
- R2: With x4_sel = 1, every legal change of the filtered pair {A,B} produces one pulse. The sequence 00→10→11→01→00 (A is the left bit) counts UP, and the reverse order counts DOWN.
- R3: With x4_sel = 0, UP is counted only on the change 00→10 (A rises while B is low) and DOWN only on 10→00 (A falls while B is low). All other legal changes produce no pulse.
- R4: up_n is low only during UP pulses and dn_n only during DOWN pulses. The two are never low together, and both are high while clk_n is high.
- R5: clk_n is low for the duration of every pulse. dir_up is 1 for UP and 0 for DOWN, and it does not change at the clock edge where clk_n rises.
- R6: A pulse with no pending count lasts pulse_width clocks. A value of 0 is treated as 1.
- R7: When a count arrives while a pulse is active, that pulse ends early and clk_n is high for at least one clock before the next pulse. Every count is issued in arrival order.
- R8: If both filtered lines change in the same clock, no pulse is made and seq_err goes to 1. It stays at 1 until reset.
- R9: After reset, up_n, dn_n and clk_n are 1, dir_up is 1, seq_err is 0, and the filtered state is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Encoder line A, asynchronous |
| enc_b | input | 1 | Encoder line B, asynchronous |
| x4_sel | input | 1 | 1: count every edge; 0: one count per cycle |
| pulse_width | input | 8 | Pulse length in clocks (0 acts as 1) |
| up_n | output | 1 | Active-low UP pulse string |
| dn_n | output | 1 | Active-low DOWN pulse string |
| clk_n | output | 1 | Active-low combined count clock |
| dir_up | output | 1 | Direction level, 1 = UP |
| seq_err | output | 1 | Sticky illegal-transition flag |

## Verification
The bench sends glitches one clock shorter than the filter window. A filter that validated too early would emit stray pulses, and the scoreboard would see pulses it never expected. Full cycles are run in both directions under both modes. In x1 mode a wrong edge choice shows up as a missing or extra count, or as a count in the wrong direction. Counts are also sent faster than a wide pulse can finish: a design that merged or dropped them would leave expected entries unconsumed, and one that swapped their order would fail the direction comparison. Simultaneous changes on both lines must raise a flag that stays set and must produce no pulse. A zero width must still give a one-clock pulse.

// File: rtl/qc_pkg.sv
package qc_pkg;
  // position of a filtered {A,B} pair in the forward (UP) Gray walk
  function automatic logic [1:0] gray_pos(input logic [1:0] ab);
    case (ab)
      2'b00:   gray_pos = 2'd0;
      2'b10:   gray_pos = 2'd1;
      2'b11:   gray_pos = 2'd2;
      default: gray_pos = 2'd3;
    endcase
  endfunction

  typedef struct packed {
    logic vld;
    logic up;
  } qc_evt_t;
endpackage

// File: rtl/qc_filter.sv
module qc_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic lvl
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      run_q  <= '0;
      lvl    <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw};
      if (sync_q[1] == lvl) begin
        run_q <= '0;
      end else if (run_q == CNT_W'(FILT_LEN - 1)) begin
        lvl   <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/qc_decode.sv
module qc_decode
  import qc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ab,
  input  logic       x4_sel,
  output qc_evt_t    evt,
  output logic       err
);
  logic [1:0] prev_q;
  logic [1:0] delta;
  logic       fwd, single, keep;

  always_comb begin
    delta  = prev_q ^ ab;
    single = (delta == 2'b01) || (delta == 2'b10);
    fwd    = (gray_pos(ab) == gray_pos(prev_q) + 2'd1);
    if (x4_sel)
      keep = 1'b1;
    else if (fwd)
      keep = (prev_q == 2'b00) && (ab == 2'b10);
    else
      keep = (prev_q == 2'b10) && (ab == 2'b00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 2'b00;
      evt    <= '0;
      err    <= 1'b0;
    end else begin
      prev_q  <= ab;
      evt.vld <= single && keep;
      evt.up  <= fwd;
      if (delta == 2'b11) err <= 1'b1;
    end
  end
endmodule

// File: rtl/qc_pulse.sv
module qc_pulse
  import qc_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PW_W  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  qc_evt_t         evt,
  input  logic [PW_W-1:0] width,
  output logic            active,
  output logic            dir
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0] dq;
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [PTR_W:0]   fill_q;
  logic [PW_W-1:0]  left_q;
  logic             push, pop;

  assign push = evt.vld && (fill_q != (PTR_W+1)'(DEPTH));
  assign pop  = !active && (fill_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq     <= '0;
      wr_q   <= '0;
      rd_q   <= '0;
      fill_q <= '0;
    end else begin
      if (push) begin
        dq[wr_q] <= evt.up;
        wr_q     <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      end
      if (pop) rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      fill_q <= fill_q + (PTR_W+1)'(push) - (PTR_W+1)'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      dir    <= 1'b1;
      left_q <= '0;
    end else if (pop) begin
      active <= 1'b1;
      dir    <= dq[rd_q];
      left_q <= (width == '0) ? PW_W'(1) : width;
    end else if (active) begin
      if (fill_q != '0 || left_q == PW_W'(1)) active <= 1'b0;
      else left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/qclk_conv.sv
module qclk_conv
  import qc_pkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int QDEPTH   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enc_a,
  input  logic       enc_b,
  input  logic       x4_sel,
  input  logic [7:0] pulse_width,
  output logic       up_n,
  output logic       dn_n,
  output logic       clk_n,
  output logic       dir_up,
  output logic       seq_err
);
  localparam int NCH = 2;

  logic [NCH-1:0] raw_ab, flt_ab;
  qc_evt_t        evt;
  logic           act, dir;

  assign raw_ab = {enc_a, enc_b};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    qc_filter #(.FILT_LEN(FILT_LEN)) u_flt (
      .clk(clk), .rst_n(rst_n), .raw(raw_ab[c]), .lvl(flt_ab[c])
    );
  end

  qc_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ab(flt_ab), .x4_sel(x4_sel),
    .evt(evt), .err(seq_err)
  );

  qc_pulse #(.DEPTH(QDEPTH), .PW_W(8)) u_pls (
    .clk(clk), .rst_n(rst_n), .evt(evt), .width(pulse_width),
    .active(act), .dir(dir)
  );

  assign clk_n  = !act;
  assign up_n   = !(act && dir);
  assign dn_n   = !(act && !dir);
  assign dir_up = dir;
endmodule

// File: rtl/qclk_conv_chk.sv
module qclk_conv_chk (
  input logic clk,
  input logic rst_n,
  input logic up_n,
  input logic dn_n,
  input logic clk_n,
  input logic dir_up,
  input logic seq_err
);
  AST_SPLIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_n == 1'b0 && dn_n == 1'b0)); // R4
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    clk_n |-> (up_n && dn_n)); // R4
  AST_CLK_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_n || !dn_n) |-> !clk_n); // R5
  AST_UP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    !up_n |-> dir_up); // R5
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_n) |-> $stable(dir_up)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err); // R8
endmodule

bind qclk_conv qclk_conv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .up_n(up_n), .dn_n(dn_n),
  .clk_n(clk_n), .dir_up(dir_up), .seq_err(seq_err)
);

// File: tb/qclk_conv_tb.sv
module qclk_conv_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enc_a = 1'b0, enc_b = 1'b0, x4_sel = 1'b1;
  logic [7:0] pulse_width = 8'd3;
  logic up_n, dn_n, clk_n, dir_up, seq_err;

  int checks = 0, errors = 0, cycles = 0;
  bit exp_q[$];
  bit width_chk = 1'b1;
  int exp_w = 3;
  bit cur_a = 0, cur_b = 0;

  always #10 clk = ~clk;

  qclk_conv u_dut (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b), .x4_sel(x4_sel),
    .pulse_width(pulse_width), .up_n(up_n), .dn_n(dn_n), .clk_n(clk_n),
    .dir_up(dir_up), .seq_err(seq_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: move to a new legal state and push the expected count
  task automatic step(input bit na, input bit nb, input int hold);
    int pa, pc;
    bit fwd, keep;
    pa = cur_a ? (cur_b ? 2 : 1) : (cur_b ? 3 : 0);
    pc = na ? (nb ? 2 : 1) : (nb ? 3 : 0);
    fwd = (pc == ((pa + 1) % 4));
    if (x4_sel) keep = 1;
    else keep = fwd ? (pa == 0 && pc == 1) : (pa == 1 && pc == 0);
    if (keep) exp_q.push_back(fwd);
    cur_a = na; cur_b = nb;
    @(negedge clk);
    enc_a = na; enc_b = nb;
    repeat (hold) @(negedge clk);
  endtask

  // monitor
  bit was_low = 0;
  int low_cnt = 0;
  bit run_dir;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!clk_n) begin
        if (!was_low) run_dir = dir_up;
        low_cnt++;
        was_low = 1;
      end else if (was_low) begin
        was_low = 0;
        if (exp_q.size() == 0) begin
          chk(0, "R1/R3 unexpected pulse", 1, 0);
        end else begin
          bit e;
          e = exp_q.pop_front();
          chk(run_dir == e, "R2/R3/R7 direction", run_dir, e);
          chk(dir_up == run_dir, "R5 dir held at clk_n rise", dir_up, run_dir);
          if (width_chk) chk(low_cnt == exp_w, "R6 width", low_cnt, exp_w);
        end
        low_cnt = 0;
      end
      if (!up_n) chk(dir_up && !clk_n, "R4 up_n only for UP", dir_up, 1);
      if (!dn_n) chk(!dir_up && !clk_n, "R4 dn_n only for DOWN", dir_up, 0);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(up_n && dn_n && clk_n, "R9 outputs idle", {up_n, dn_n, clk_n}, 7);
    chk(dir_up == 1, "R9 dir_up", dir_up, 1);
    chk(seq_err == 0, "R9 seq_err", seq_err, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R2 x4 mode, both directions
    x4_sel = 1; pulse_width = 8'd3; exp_w = 3;
    repeat (2) begin
      step(1,0,20); step(1,1,20); step(0,1,20); step(0,0,20);
    end
    step(0,1,20); step(1,1,20); step(1,0,20); step(0,0,20);

    // R1 glitch one clock short of the window
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); enc_a = 1;
      repeat (3) @(negedge clk); enc_a = 0;
      repeat (15) @(negedge clk);
    end
    chk(exp_q.size() == 0, "R1 glitch ignored", exp_q.size(), 0);

    // R3 x1 mode
    x4_sel = 0; pulse_width = 8'd5; exp_w = 5;
    repeat (2) begin
      step(1,0,20); step(1,1,20); step(0,1,20); step(0,0,20);
    end
    step(0,1,20); step(1,1,20); step(1,0,20); step(0,0,20);
    step(1,0,20); step(0,0,20);

    // R6 zero width treated as one
    x4_sel = 1; pulse_width = 8'd0; exp_w = 1;
    step(1,0,20); step(0,0,20);

    // R7 counts faster than a wide pulse
    pulse_width = 8'd60; width_chk = 0;
    repeat (3) begin
      step(1,0,6); step(1,1,6); step(0,1,6); step(0,0,6);
    end
    step(0,1,6); step(1,1,6);
    step(0,1,6); step(0,0,200);
    chk(exp_q.size() == 0, "R7 no count lost", exp_q.size(), 0);
    width_chk = 1; pulse_width = 8'd2; exp_w = 2;

    // R8 simultaneous change
    chk(seq_err == 0, "R8 flag clear before", seq_err, 0);
    @(negedge clk); enc_a = 1; enc_b = 1;
    repeat (20) @(negedge clk);
    chk(seq_err == 1, "R8 flag set", seq_err, 1);
    cur_a = 1; cur_b = 1;
    step(0,1,20); step(0,0,20);
    chk(seq_err == 1, "R8 flag sticky", seq_err, 1);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all expected pulses seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule